// File: doc/BRIEF.md
# Multi-Ring Transfer Arbiter

This block decides which point-to-point transfers may use an on-chip ring interconnect of eight stations. The interconnect carries data on four one-way rings: two rotate clockwise and two rotate counter-clockwise. A station raises a request that names a destination station. The arbiter finds a ring and a direction whose path is free, and grants the transfer. The transfer then keeps its stretch of ring until the station reports that it has finished.

Each ring may hold several transfers at once, provided their paths never touch a common segment, with a fixed cap per ring. A transfer always goes the short way round. A transfer to the station exactly opposite may go either way: the less busy direction is tried first, and the other direction is used when the first has no room. Requests are served one grant per cycle, in round-robin order of source station. A request that names its own source is flagged as an error and is never served.

Top module: `ring_xfer_arb`

## Requirements
- R1: Rings 0 and 1 turn clockwise (station k to k+1 mod 8) and rings 2 and 3 turn counter-clockwise (station k to k-1 mod 8). A transfer holds every segment from its source up to, but not including, its destination, where segment k is the link leaving station k in that ring's direction. gnt_ring_o reports the ring index.
- R2: When the clockwise distance (dst - src) mod 8 is 1 to 3, the grant is on a clockwise ring. When it is 5 to 7, the grant is on a counter-clockwise ring.
- R3: Two active transfers on the same ring never share a segment. A request that fits on no ring of an allowed direction is not granted, and it waits until room is freed.
- R4: No ring carries more than 3 active transfers at once.
- R5: A request at distance 4 first tries the direction whose two rings together hold fewer active transfers, with clockwise chosen on a tie. If that direction has no room, the request falls back to the other direction.
- R6: Within a direction, the lower-numbered ring that fits is chosen.
- R7: At most one grant is made per cycle. A request that is eligible in cycle c pulses gnt_o in cycle c+1. Eligible stations are served in round-robin order, starting after the station granted last, and station 0 comes first after reset.
- R8: A granted station keeps its ring (gnt_ring_o stays stable) until it pulses done_i. Its segments are free for arbitration in the following cycle. A request from a station that holds a grant is ignored.
- R9: A request whose destination equals its own station index sets err_o for that station in the next cycle, for as long as it is held, and it is never granted.
- R10: After reset, gnt_o and err_o are low and every ring is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 8 | Per-station request, held until granted |
| req_dst_i | input | 8x3 | Per-station destination index |
| done_i | input | 8 | Per-station end-of-transfer pulse |
| gnt_o | output | 8 | Per-station one-cycle grant pulse |
| gnt_ring_o | output | 8x2 | Ring held by each station while granted |
| err_o | output | 8 | Per-station self-destination error |

## Verification
The bench builds the block with its default configuration: eight stations, two rings per direction and a cap of three per ring. With these values, half-way requests occur at distance 4. A ring can be filled to its cap with short hops, and both rings of one direction can be blocked by only two transfers, which triggers the direction fallback. The scenarios pack non-overlapping transfers onto one ring, hit the cap, hold a request that overlaps until a done frees it, and order three requests raised at once through the round-robin pointer.

// File: rtl/ring_xfer_arb_pkg.sv
package ring_xfer_arb_pkg;
    parameter int N_ST = 8;               // stations on the ring
    parameter int RPD  = 2;               // rings per direction
    parameter int CAP  = 3;               // concurrent transfers per ring
    localparam int NR   = 2 * RPD;
    localparam int SW   = $clog2(N_ST);
    localparam int RW   = $clog2(NR);
    localparam int CNTW = $clog2(N_ST + 1);

    typedef logic [N_ST-1:0] seg_t;
    typedef enum logic { DIR_CW = 1'b0, DIR_CCW = 1'b1 } dir_e;

    typedef struct packed {
        logic          busy;
        logic [RW-1:0] ring;
        seg_t          segs;
    } slot_t;

    typedef struct packed {
        logic          ok;
        logic [RW-1:0] ring;
        seg_t          segs;
    } route_t;

    function automatic int cw_dist(int s, int d);
        return (d - s + N_ST) % N_ST;
    endfunction

    function automatic dir_e ring_dir(int r);
        return (r < RPD) ? DIR_CW : DIR_CCW;
    endfunction

    // Segments held by a path from s to d travelling in direction dir.
    function automatic seg_t path_segs(int s, int d, dir_e dir);
        seg_t m;
        int   hops;
        int   idx;
        m    = '0;
        hops = cw_dist(s, d);
        if (dir == DIR_CCW && hops != 0) hops = N_ST - hops;
        for (int k = 0; k < N_ST; k++) begin
            if (k < hops) begin
                idx = (dir == DIR_CW) ? (s + k) % N_ST : (s - k + N_ST) % N_ST;
                m[idx] = 1'b1;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/ring_xfer_arb_occ.sv
module ring_xfer_arb_occ
    import ring_xfer_arb_pkg::*;
(
    input  slot_t [N_ST-1:0]           slots_i,
    output seg_t  [NR-1:0]             occ_o,
    output logic  [NR-1:0][CNTW-1:0]   cnt_o
);
    always_comb begin
        for (int r = 0; r < NR; r++) begin
            occ_o[r] = '0;
            cnt_o[r] = '0;
            for (int i = 0; i < N_ST; i++) begin
                if (slots_i[i].busy && slots_i[i].ring == RW'(r)) begin
                    occ_o[r] = occ_o[r] | slots_i[i].segs;
                    cnt_o[r] = cnt_o[r] + CNTW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ring_xfer_arb_route.sv
module ring_xfer_arb_route
    import ring_xfer_arb_pkg::*;
#(
    parameter int SRC = 0
) (
    input  logic [SW-1:0]            dst_i,
    input  seg_t [NR-1:0]            occ_i,
    input  logic [NR-1:0][CNTW-1:0]  cnt_i,
    output route_t                   route_o
);
    always_comb begin
        int   dcw;
        int   load_cw;
        int   load_ccw;
        logic half;
        dir_e first;
        dir_e dir;
        seg_t segs;

        dcw      = cw_dist(SRC, int'(dst_i));
        half     = (dcw == N_ST / 2);
        load_cw  = 0;
        load_ccw = 0;
        for (int r = 0; r < NR; r++) begin
            if (ring_dir(r) == DIR_CW) load_cw  = load_cw  + int'(cnt_i[r]);
            else                       load_ccw = load_ccw + int'(cnt_i[r]);
        end

        if (dcw < N_ST / 2)      first = DIR_CW;
        else if (dcw > N_ST / 2) first = DIR_CCW;
        else                     first = (load_ccw < load_cw) ? DIR_CCW : DIR_CW;

        route_o = '0;
        for (int pass = 0; pass < 2; pass++) begin
            dir  = (pass == 0) ? first : ((first == DIR_CW) ? DIR_CCW : DIR_CW);
            segs = path_segs(SRC, int'(dst_i), dir);
            if ((pass == 0 || half) && !route_o.ok) begin
                for (int r = 0; r < NR; r++) begin
                    if (!route_o.ok && ring_dir(r) == dir &&
                        int'(cnt_i[r]) < CAP && (occ_i[r] & segs) == '0) begin
                        route_o.ok   = 1'b1;
                        route_o.ring = RW'(r);
                        route_o.segs = segs;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ring_xfer_arb_rr.sv
module ring_xfer_arb_rr
    import ring_xfer_arb_pkg::*;
(
    input  logic [N_ST-1:0] elig_i,
    input  logic [SW-1:0]   last_i,
    output logic            hit_o,
    output logic [SW-1:0]   win_o
);
    always_comb begin
        int idx;
        hit_o = 1'b0;
        win_o = '0;
        for (int k = 1; k <= N_ST; k++) begin
            idx = (int'(last_i) + k) % N_ST;
            if (!hit_o && elig_i[idx]) begin
                hit_o = 1'b1;
                win_o = SW'(idx);
            end
        end
    end
endmodule

// File: rtl/ring_xfer_arb.sv
module ring_xfer_arb
    import ring_xfer_arb_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_ST-1:0]            req_valid_i,
    input  logic [N_ST-1:0][SW-1:0]    req_dst_i,
    input  logic [N_ST-1:0]            done_i,
    output logic [N_ST-1:0]            gnt_o,
    output logic [N_ST-1:0][RW-1:0]    gnt_ring_o,
    output logic [N_ST-1:0]            err_o
);
    slot_t  [N_ST-1:0]          slots_q;
    seg_t   [NR-1:0]            occ;
    logic   [NR-1:0][CNTW-1:0]  cnt;
    route_t [N_ST-1:0]          route;
    logic   [N_ST-1:0]          elig;
    logic   [SW-1:0]            last_q;
    logic                       hit;
    logic   [SW-1:0]            win;

    ring_xfer_arb_occ u_occ (
        .slots_i (slots_q),
        .occ_o   (occ),
        .cnt_o   (cnt)
    );

    for (genvar i = 0; i < N_ST; i++) begin : g_st
        ring_xfer_arb_route #(.SRC(i)) u_route (
            .dst_i   (req_dst_i[i]),
            .occ_i   (occ),
            .cnt_i   (cnt),
            .route_o (route[i])
        );
        assign elig[i] = req_valid_i[i] && !slots_q[i].busy &&
                         req_dst_i[i] != SW'(i) && route[i].ok;
        assign gnt_ring_o[i] = slots_q[i].ring;
    end

    ring_xfer_arb_rr u_rr (
        .elig_i (elig),
        .last_i (last_q),
        .hit_o  (hit),
        .win_o  (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
            last_q  <= SW'(N_ST - 1);
            gnt_o   <= '0;
            err_o   <= '0;
        end else begin
            gnt_o <= '0;
            for (int i = 0; i < N_ST; i++) begin
                err_o[i] <= req_valid_i[i] && !slots_q[i].busy && req_dst_i[i] == SW'(i);
                if (done_i[i] && slots_q[i].busy) slots_q[i].busy <= 1'b0;
            end
            if (hit) begin
                slots_q[win] <= '{busy: 1'b1, ring: route[win].ring, segs: route[win].segs};
                gnt_o[win]   <= 1'b1;
                last_q       <= win;
            end
        end
    end
endmodule

// File: rtl/ring_xfer_arb_chk.sv
module ring_xfer_arb_chk
    import ring_xfer_arb_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic [N_ST-1:0][SW-1:0]    req_dst_i,
    input logic [N_ST-1:0]            done_i,
    input logic [N_ST-1:0]            gnt_o,
    input logic [N_ST-1:0][RW-1:0]    gnt_ring_o,
    input logic [N_ST-1:0]            err_o,
    input slot_t [N_ST-1:0]           slots_q,
    input logic [NR-1:0][CNTW-1:0]    cnt
);
    p_one_grant_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    for (genvar r = 0; r < NR; r++) begin : g_ring
        p_ring_cap_r4: assert property (@(posedge clk) disable iff (rst)
            int'(cnt[r]) <= CAP);
    end

    for (genvar i = 0; i < N_ST; i++) begin : g_st
        p_self_never_r9: assert property (@(posedge clk) disable iff (rst)
            gnt_o[i] |-> $past(req_dst_i[i]) != SW'(i));
        p_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
            err_o[i] |-> !gnt_o[i]);
        p_hold_ring_r8: assert property (@(posedge clk) disable iff (rst)
            slots_q[i].busy && !done_i[i] |=> slots_q[i].busy && $stable(gnt_ring_o[i]));
        p_short_cw_r2: assert property (@(posedge clk) disable iff (rst)
            gnt_o[i] && cw_dist(i, int'($past(req_dst_i[i]))) < N_ST / 2
            |-> int'(gnt_ring_o[i]) < RPD);
        p_short_ccw_r2: assert property (@(posedge clk) disable iff (rst)
            gnt_o[i] && cw_dist(i, int'($past(req_dst_i[i]))) > N_ST / 2
            |-> int'(gnt_ring_o[i]) >= RPD);
        for (genvar j = i + 1; j < N_ST; j++) begin : g_pair
            p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
                slots_q[i].busy && slots_q[j].busy && slots_q[i].ring == slots_q[j].ring
                |-> (slots_q[i].segs & slots_q[j].segs) == '0);
        end
    end
endmodule

bind ring_xfer_arb ring_xfer_arb_chk u_chk (.*);

// File: tb/ring_xfer_arb_bench.sv
`timescale 1ns/1ps
module ring_xfer_arb_bench;
    import ring_xfer_arb_pkg::*;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [N_ST-1:0]          req_valid = '0;
    logic [N_ST-1:0][SW-1:0]  req_dst = '0;
    logic [N_ST-1:0]          done = '0;
    logic [N_ST-1:0]          gnt;
    logic [N_ST-1:0][RW-1:0]  gnt_ring;
    logic [N_ST-1:0]          err;

    typedef struct { int st; int ring; int cyc; string tag; } exp_t;
    exp_t q[$];
    int   cyc = 0;
    int   nchk = 0;
    int   nerr = 0;
    bit   ended = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ring_xfer_arb u_ring_xfer_arb (
        .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_dst_i(req_dst),
        .done_i(done), .gnt_o(gnt), .gnt_ring_o(gnt_ring), .err_o(err)
    );

    task automatic report;
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every grant must match the head of the queue.
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < N_ST; i++) begin
                if (gnt[i]) begin
                    nchk++;
                    if (q.size() == 0) begin
                        nerr++;
                        $display("FAIL R7 unexpected grant: actual station %0d expected none", i);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        if (e.st != i || e.ring != int'(gnt_ring[i]) || e.cyc != cyc) begin
                            nerr++;
                            $display("FAIL %s grant: actual st %0d ring %0d cyc %0d expected st %0d ring %0d cyc %0d",
                                     e.tag, i, gnt_ring[i], cyc, e.st, e.ring, e.cyc);
                        end
                    end
                end
            end
        end
    end

    task automatic expect_gnt(int st, int ring, int lat, string tag);
        exp_t e;
        e.st = st; e.ring = ring; e.cyc = cyc + lat; e.tag = tag;
        q.push_back(e);
    endtask

    // Raise a request that must be granted in the next cycle, then drop it.
    task automatic xfer(int st, int dst, int ring, string tag);
        req_valid[st] = 1'b1;
        req_dst[st]   = SW'(dst);
        expect_gnt(st, ring, 1, tag);
        @(negedge clk);
        req_valid[st] = 1'b0;
    endtask

    task automatic release_st(int st);
        done[st] = 1'b1;
        @(negedge clk);
        done[st] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: idle after reset
        chk("R10", "gnt after reset", int'(gnt), 0);
        chk("R10", "err after reset", int'(err), 0);
        @(negedge clk);

        // R1 R6: empty rings, short clockwise hop lands on ring 0
        xfer(1, 3, 0, "R1");
        // R2: clockwise distance 5 takes a counter-clockwise ring
        xfer(2, 7, 2, "R2");
        // R3 R6: 0->2 overlaps 1->3 on ring 0, so ring 1
        xfer(0, 2, 1, "R3");
        // R3: 3->5 shares no segment with 1->3, packs on ring 0
        xfer(3, 5, 0, "R3");
        // R4: third transfer fills ring 0, fourth spills to ring 1
        xfer(5, 6, 0, "R4");
        xfer(6, 7, 1, "R4");
        // R8: rings held while busy
        chk("R8", "ring of station 1", int'(gnt_ring[1]), 0);
        chk("R8", "ring of station 2", int'(gnt_ring[2]), 2);
        chk("R8", "ring of station 0", int'(gnt_ring[0]), 1);

        // R3: 7->1 needs segments 7,0; ring 0 full, ring 1 holds segment 0
        req_valid[7] = 1'b1;
        req_dst[7]   = SW'(1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R3", "blocked request grant", int'(gnt), 0);
        end
        // R8: freeing 0->2 lets 7->1 onto ring 1 two cycles after done
        done[0] = 1'b1;
        expect_gnt(7, 1, 2, "R8");
        @(negedge clk);
        done[0] = 1'b0;
        @(negedge clk);
        req_valid[7] = 1'b0;

        // R5: half-way, counter-clockwise less loaded; ring 2 overlaps so ring 3
        xfer(4, 0, 3, "R5");
        for (int s = 1; s < N_ST; s++) release_st(s);
        @(negedge clk);
        chk("R8", "no grants after releases", int'(gnt), 0);

        // R5: tie goes clockwise, then fallback when both clockwise rings block
        xfer(0, 4, 0, "R5");
        xfer(1, 3, 1, "R6");
        xfer(7, 5, 2, "R2");
        xfer(6, 5, 3, "R3");
        xfer(2, 6, 3, "R5");
        release_st(0); release_st(1); release_st(7); release_st(6); release_st(2);

        // R7: round robin after station 2 serves 3, then 6, then 1
        req_valid[1] = 1'b1; req_dst[1] = SW'(2);
        req_valid[3] = 1'b1; req_dst[3] = SW'(4);
        req_valid[6] = 1'b1; req_dst[6] = SW'(7);
        expect_gnt(3, 0, 1, "R7");
        expect_gnt(6, 0, 2, "R7");
        expect_gnt(1, 0, 3, "R7");
        @(negedge clk); req_valid[3] = 1'b0;
        @(negedge clk); req_valid[6] = 1'b0;
        @(negedge clk); req_valid[1] = 1'b0;
        release_st(3); release_st(6); release_st(1);

        // R9: self destination flags error, never grants
        req_valid[5] = 1'b1;
        req_dst[5]   = SW'(5);
        @(negedge clk);
        chk("R9", "err on self request", int'(err[5]), 1);
        chk("R9", "no grant on self request", int'(gnt), 0);
        @(negedge clk);
        chk("R9", "err while held", int'(err[5]), 1);
        req_valid[5] = 1'b0;
        @(negedge clk);
        chk("R9", "err after drop", int'(err[5]), 0);

        // R8: new request from a busy station is ignored
        xfer(0, 1, 0, "R8");
        req_valid[0] = 1'b1;
        req_dst[0]   = SW'(2);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8", "busy station grant", int'(gnt), 0);
            chk("R8", "busy station ring", int'(gnt_ring[0]), 0);
        end
        req_valid[0] = 1'b0;
        release_st(0);
        repeat (2) @(negedge clk);

        chk("R7", "pending expected grants", q.size(), 0);
        report();
    end
endmodule